// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits on a synchronous clock and runs an external asynchronous static RAM that has a 16-bit data bus split into a high and a low byte lane. A client sends one request at a time over a valid/ready handshake: a write flag, an address, write data and a two-bit lane mask. The controller produces the memory's two chip selects (one active low, one active high), the active-low output and write strobes and the active-low lane strobes. It also produces the direction control of the data bus as a split output value, an output enable and an input value. Read data comes back with a one-cycle valid pulse.

Every timing figure is given in nanoseconds and turned into a cycle count, rounded up, from the clock period. A state machine runs the sequence. The states are IDLE (low-power standby), RD_ACC (read access), RD_REL (wait for the memory to release the bus after a read), WR_PULSE (write strobe low) and WR_HOLD (strobe high with everything else held). The transitions are: IDLE to RD_ACC or WR_PULSE on an accepted request, RD_ACC to RD_REL when the access count expires, RD_REL to IDLE when the release count expires, WR_PULSE to WR_HOLD when the pulse count expires, and WR_HOLD to IDLE after one cycle. With the defaults (10 ns clock) a read holds the output strobe low for 5 cycles, the release wait is 2 cycles and the write strobe is low for 4 cycles.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory is in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_lane_n`=2'b11, `mem_dq_oe`=0, and `rsp_valid`=0 after reset.
- R2: A read holds both chip selects active and `mem_oe_n` low for exactly RD_CYC cycles, where RD_CYC is the larger of ceil(45 ns / clock) and ceil(45 ns / clock). `rsp_valid` is a one-cycle pulse seen RD_CYC+1 cycles after the accepting edge.
- R3: Bit 1 of `req_be` enables the high lane (data bits 15:8, `mem_lane_n[1]`) and bit 0 enables the low lane (bits 7:0, `mem_lane_n[0]`). A lane strobe is low only for an enabled lane. A write leaves a disabled lane's byte unchanged, and a read returns zero on a disabled lane.
- R4: A write holds `mem_we_n` low for exactly WR_CYC cycles, where WR_CYC is the largest of ceil(35 ns), ceil(40 ns), ceil(25 ns) and ceil(45 ns) minus one, all divided by the clock and rounded up. This is followed by one cycle with `mem_we_n` high while the address, chip selects and lane strobes stay as they were.
- R5: During the write strobe and the hold cycle the controller drives `mem_dq_out` with the request's write data and keeps `mem_dq_oe` high.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. After `mem_oe_n` rises, `mem_dq_oe` stays low for more than REL_CYC = ceil(15 ns / clock) cycles.
- R7: `mem_oe_n` never falls in the cycle after one in which `mem_dq_oe` was high.
- R8: `req_ready` is high only in standby. A request whose `req_valid` is held while the controller is busy waits and is accepted once, when ready returns.
- R9: A request with mask 2'b00 is accepted and completes with both lane strobes high throughout. A write leaves memory unchanged, and a read returns zero with a `rsp_valid` pulse.
- R10: `mem_we_n` and `mem_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | LANES | Lane mask, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_lane_n | output | LANES | Active-low lane strobes, bit 1 = high byte |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Data bus as seen from memory |

## Verification
The two things that can land in the same cycle are the end of one transfer and the start of a transfer in the opposite direction: the controller must stop driving and open the memory's outputs, or release them and start driving. The bench provokes this by raising the next request while the previous one is still running, so that the new one is accepted on the first standby cycle. It also mixes writes and reads in a random order. A bus monitor counts the cycles since the output strobe rose and checks whether the controller drove in the cycle before the output strobe fell. A write-then-read pair therefore fails at once if the turnaround gap is missing. A read-then-write pair fails at once if the release wait is too short.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REL,
        ST_WR_PULSE,
        ST_WR_HOLD
    } asram_state_e;

    // ceil(ns / clk_ns), at least one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_capture.sv
module asram_lane_capture #(
    parameter int unsigned LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] bus_in,
    output logic [LANES*8-1:0] data_q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[l*8 +: 8] <= '0;
            end else if (capture) begin
                data_q[l*8 +: 8] <= lane_en[l] ? bus_in[l*8 +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_RC_NS   = 45,
    parameter int unsigned T_AA_NS   = 45,
    parameter int unsigned T_WC_NS   = 45,
    parameter int unsigned T_PWE_NS  = 35,
    parameter int unsigned T_AW_NS   = 40,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_HZOE_NS = 15,
    localparam int unsigned LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC  = cyc_max(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS));
    localparam int unsigned WC_REST = (ns2cyc(T_WC_NS, CLK_NS) > 1) ? ns2cyc(T_WC_NS, CLK_NS) - 1 : 1;
    localparam int unsigned WR_CYC  = cyc_max(cyc_max(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                              cyc_max(ns2cyc(T_SD_NS, CLK_NS), WC_REST));
    localparam int unsigned REL_CYC = ns2cyc(T_HZOE_NS, CLK_NS);
    localparam int unsigned MAX_CYC = cyc_max(cyc_max(RD_CYC, WR_CYC), REL_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam int unsigned GAP_W   = $clog2(REL_CYC + 2);

    asram_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              phase_done;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              capture;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_PULSE : ST_RD_ACC;
            ST_RD_ACC:   if (phase_done) state_d = ST_RD_REL;
            ST_RD_REL:   if (phase_done) state_d = ST_IDLE;
            ST_WR_PULSE: if (phase_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // phase length loaded when a state is entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_RD_ACC:   tmr_val = CNT_W'(RD_CYC - 1);
            ST_RD_REL:   tmr_val = CNT_W'(REL_CYC - 1);
            ST_WR_PULSE: tmr_val = CNT_W'(WR_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (phase_done)
    );

    assign capture = (state_q == ST_RD_ACC) && phase_done;

    asram_lane_capture #(.LANES(LANES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane_en (be_q),
        .bus_in  (mem_dq_in),
        .data_q  (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
        end
    end

    // output decode
    always_comb begin
        req_ready  = 1'b0;
        mem_ce1_n  = 1'b1;
        mem_ce2    = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_lane_n = '1;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ACC: begin
                mem_ce1_n  = 1'b0;
                mem_ce2    = 1'b1;
                mem_oe_n   = 1'b0;
                mem_lane_n = ~be_q;
            end
            ST_RD_REL: ;
            ST_WR_PULSE: begin
                mem_ce1_n  = 1'b0;
                mem_ce2    = 1'b1;
                mem_we_n   = 1'b0;
                mem_lane_n = ~be_q;
                mem_dq_oe  = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_ce1_n  = 1'b0;
                mem_ce2    = 1'b1;
                mem_lane_n = ~be_q;
                mem_dq_oe  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // cycles since the output strobe was last low (saturating)
    logic [GAP_W-1:0] oe_gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_gap_q <= GAP_W'(REL_CYC + 1);
        end else if (!mem_oe_n) begin
            oe_gap_q <= '0;
        end else if (oe_gap_q != GAP_W'(REL_CYC + 1)) begin
            oe_gap_q <= oe_gap_q + 1'b1;
        end
    end

    // R10
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_gap_q >= GAP_W'(REL_CYC)));

    // R7
    drive_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && $stable(mem_addr)
                             && $stable(mem_lane_n) && mem_dq_oe));

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int RD_CYC  = (45 + 9) / 10;
    localparam int WR_CYC  = 4;
    localparam int REL_CYC = (15 + 9) / 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0] mem_lane_n;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(10)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [DW-1:0] model_mem [256];
    logic [DW-1:0] ref_mem [256];
    logic [DW-1:0] exp_rdata;
    logic [1:0] cur_be;
    int rd_acc_cyc = 0, we_cnt = 0, oe_cnt = 0, since_oe = 100;
    int n_rd_issued = 0, n_rsp = 0;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    logic [AW-1:0] w_addr;
    logic [1:0] w_lane;
    logic [DW-1:0] w_data;
    bit ended = 0;

    // memory model: disabled lanes show a junk pattern
    assign mem_dq_in = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ?
        { mem_lane_n[1] ? 8'hA5 : model_mem[mem_addr][15:8],
          mem_lane_n[0] ? 8'hA5 : model_mem[mem_addr][7:0] } : 16'h5A5A;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic finish_run();
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // bus monitor
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            cyc++;
            if (!mem_we_n && !mem_oe_n) chk(0, "R10", {mem_we_n, mem_oe_n}, 2'b11);
            if (!mem_we_n) begin
                we_cnt++;
                w_addr = mem_addr; w_lane = mem_lane_n; w_data = mem_dq_out;
                if (mem_ce1_n || !mem_ce2 || !mem_dq_oe)
                    chk(0, "R5", {mem_ce1_n, mem_ce2, mem_dq_oe}, 3'b011);
            end else if (!prev_we_n) begin
                chk(we_cnt == WR_CYC, "R4", we_cnt, WR_CYC);
                chk(mem_addr == w_addr && mem_lane_n == w_lane && !mem_ce1_n && mem_ce2,
                    "R4 hold", {mem_addr, mem_lane_n}, {w_addr, w_lane});
                chk(mem_dq_oe && mem_dq_out == w_data, "R5", mem_dq_out, w_data);
                chk(mem_lane_n == ~cur_be, "R3 lane strobes", mem_lane_n, ~cur_be);
                if (!w_lane[1]) model_mem[w_addr][15:8] = w_data[15:8];
                if (!w_lane[0]) model_mem[w_addr][7:0]  = w_data[7:0];
                we_cnt = 0;
            end
            if (!mem_oe_n) begin
                oe_cnt++;
                if (mem_dq_oe) chk(0, "R6 contention", mem_dq_oe, 0);
                if (prev_oe_n) chk(!prev_dq_oe, "R7", prev_dq_oe, 0);
                if (mem_lane_n != ~cur_be) chk(0, "R3 read lanes", mem_lane_n, ~cur_be);
                since_oe = 0;
            end else begin
                if (!prev_oe_n) chk(oe_cnt == RD_CYC, "R2 strobe", oe_cnt, RD_CYC);
                oe_cnt = 0;
                if (since_oe < 100) since_oe++;
            end
            if (mem_dq_oe && !prev_dq_oe)
                chk(since_oe > REL_CYC, "R6 release", since_oe, REL_CYC + 1);
            if (req_valid && req_ready) begin
                cur_be = req_be;
                chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe,
                    "R1 standby", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 7'b1011110);
                if (!req_write) rd_acc_cyc = cyc;
            end
            if (!req_ready && (mem_ce1_n && mem_we_n && mem_oe_n) && prev_oe_n && prev_we_n && mem_dq_oe)
                chk(0, "R8", req_ready, 1);
            if (rsp_valid) begin
                n_rsp++;
                chk(cyc - rd_acc_cyc == RD_CYC + 1, "R2 latency", cyc - rd_acc_cyc, RD_CYC + 1);
                chk(rsp_rdata == exp_rdata, "R3 read data", rsp_rdata, exp_rdata);
            end
            prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, input bit wait_done);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        if (wr) ref_mem[a] = (ref_mem[a] & ~lane_mask(be)) | (d & lane_mask(be));
        else begin
            exp_rdata = ref_mem[a] & lane_mask(be);
            n_rd_issued++;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
        if (wait_done) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 16'(i * 257);
            ref_mem[i]   = 16'(i * 257);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lane_n == 2'b11
            && !mem_dq_oe && !rsp_valid, "R1 reset",
            {req_ready, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_valid},
            9'b110111100);

        // directed: full write / full read
        issue(1, 8'h10, 16'hBEEF, 2'b11, 1);
        issue(0, 8'h10, 16'h0000, 2'b11, 1);
        // R3 low lane only write, then full read
        issue(1, 8'h10, 16'h1234, 2'b01, 1);
        issue(0, 8'h10, 16'h0000, 2'b11, 1);
        // R3 high lane only read
        issue(0, 8'h10, 16'h0000, 2'b10, 1);
        // R9 empty mask write and read
        issue(1, 8'h20, 16'hFFFF, 2'b00, 1);
        issue(0, 8'h20, 16'h0000, 2'b00, 1);
        issue(0, 8'h20, 16'h0000, 2'b11, 1);
        // R8/R6/R7: back-to-back turnarounds with request held while busy
        issue(1, 8'h30, 16'hCAFE, 2'b11, 0);
        issue(0, 8'h30, 16'h0000, 2'b11, 0);
        @(negedge clk);
        chk(!req_ready, "R8 busy", req_ready, 0);
        while (!req_ready) @(negedge clk);
        issue(1, 8'h31, 16'h5555, 2'b10, 1);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 16);
            issue(bit'($urandom % 2), a, DW'($urandom), 2'($urandom), bit'($urandom % 2));
            if (!req_ready) begin
                @(negedge clk);
                while (!req_ready) @(negedge clk);
            end
            repeat ($urandom % 3) @(posedge clk);
        end
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(n_rsp == n_rd_issued, "R8 no loss", n_rsp, n_rd_issued);
        finish_run();
    end
endmodule